// File: doc/BRIEF.md
# Streaming 3x3 Median Filter

The block filters an image that arrives one column slice at a time. Each output is the median of a 3x3 neighbourhood. Every slice holds three vertically adjacent pixels: top, middle and bottom. The block keeps the two most recent slices of the current row. When a third slice arrives, the block forms a nine-pixel window from it and the two held slices. A pipelined odd-even transposition network of compare-and-swap cells then sorts the window. The network has nine rounds and each round is one register stage. The centre element of the sorted result is emitted with a valid flag.

The host first pulses `start` with the row length on `dim_in`. The block captures that length once and holds it. The host then presents slices in row order. A parameter selects how many pixels arrive per beat. With three lanes, one beat carries a whole slice and the block can emit one median per cycle. With one lane, the three pixels of a slice arrive in three separate beats, so results come out at most once every three cycles. The block reuses the six pixels it already holds, so only new slices need to be fetched.

Top module: `median3x3_stream`

## Requirements
- R1: After reset, `out_valid` is low. Input beats are ignored until the first `start` pulse.
- R2: `out_pix` is the 5th smallest of the nine window pixels, counting ties. The window is the just-completed slice plus the two slices before it in the same row.
- R3: `out_valid` rises for one cycle at the 9th rising edge after the edge that accepted the beat completing the window's newest slice. Every window produces exactly one result.
- R4: With CHANNELS=3, every accepted beat is one slice. The top pixel is in `in_pix[7:0]`, the middle pixel in `in_pix[15:8]` and the bottom pixel in `in_pix[23:16]`. Back-to-back beats give back-to-back results.
- R5: With CHANNELS=1, a slice is three accepted beats in the order top, middle, bottom. Idle cycles may fall between them. `out_valid` is never high in two consecutive cycles.
- R6: Once a row has three slices, each further slice produces one more window. That window reuses the two previous slices.
- R7: A row is `dim` slices long. The first two slices of a row produce no result, so a row yields `dim`-2 results, and no window mixes slices from two rows. If `dim` is below 3, there is no output.
- R8: `dim_in` is sampled only in a `start` cycle. Changes to it at any other time have no effect.
- R9: A `start` pulse restarts the slice and lane position, and a beat presented in the same cycle is ignored. Results already inside the sorting pipeline still emerge on schedule.
- R10: A cycle with `in_valid` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that captures `dim_in` and restarts position tracking |
| dim_in | input | DIM_W (12) | Row length in slices |
| in_valid | input | 1 | Beat on `in_pix` is valid |
| in_pix | input | CHANNELS*PIX_W (24) | One slice (3 lanes) or one pixel (1 lane) |
| out_valid | output | 1 | `out_pix` holds a median this cycle |
| out_pix | output | PIX_W (8) | Median of the window |

## Verification
The case where two functions share a cycle is a restart during live sorting. A `start` pulse, carrying a valid beat, is issued while earlier windows are still in the nine-stage network. That same cycle both restarts position tracking and carries the older results forward. The per-cycle reference model expects two things: every in-flight median emerges at its scheduled edge, and the beat coinciding with `start` contributes nothing. Any lost, shifted or extra result therefore shows up as a timing or value mismatch.

// File: rtl/median3x3_stream.sv
module median3x3_stream #(
  parameter int PIX_W    = 8,
  parameter int CHANNELS = 3,
  parameter int DIM_W    = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [DIM_W-1:0]          dim_in,
  input  logic                      in_valid,
  input  logic [CHANNELS*PIX_W-1:0] in_pix,
  output logic                      out_valid,
  output logic [PIX_W-1:0]          out_pix
);
  localparam int TAPS   = 9;
  localparam int ROUNDS = TAPS;
  localparam int MID    = TAPS / 2;
  localparam int COL_W  = 3 * PIX_W;
  localparam logic [DIM_W-1:0] MIN_DIM = DIM_W'(3);
  localparam logic [DIM_W-1:0] FIRST_WIN = DIM_W'(2);

  logic [DIM_W-1:0] dim_q, col_idx;
  logic             running, win_vld;
  logic [COL_W-1:0] h0, h1, h2;
  logic             col_done;
  logic [COL_W-1:0] new_col;
  logic             accept;

  assign accept = running & in_valid & ~start;

  generate
    if (CHANNELS == 3) begin : g_wide
      assign col_done = accept;
      assign new_col  = in_pix;
    end else begin : g_narrow
      logic [1:0]         lane;
      logic [2*PIX_W-1:0] part;
      assign col_done = accept && (lane == 2'd2);
      assign new_col  = {in_pix[PIX_W-1:0], part};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane <= '0;
          part <= '0;
        end else if (start) begin
          lane <= '0;
        end else if (accept) begin
          if (lane == 2'd0) part[PIX_W-1:0] <= in_pix[PIX_W-1:0];
          if (lane == 2'd1) part[2*PIX_W-1:PIX_W] <= in_pix[PIX_W-1:0];
          lane <= (lane == 2'd2) ? 2'd0 : lane + 2'd1;
        end
      end
      // R5
      spaced_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dim_q   <= '0;
      running <= 1'b0;
      col_idx <= '0;
      win_vld <= 1'b0;
      h0 <= '0;
      h1 <= '0;
      h2 <= '0;
    end else if (start) begin
      dim_q   <= dim_in;
      running <= 1'b1;
      col_idx <= '0;
      win_vld <= 1'b0;
    end else begin
      win_vld <= col_done && (col_idx >= FIRST_WIN) && (dim_q >= MIN_DIM);
      if (col_done) begin
        h0 <= h1;
        h1 <= h2;
        h2 <= new_col;
        col_idx <= (col_idx == dim_q - DIM_W'(1)) ? '0 : col_idx + DIM_W'(1);
      end
    end
  end

  function automatic logic [TAPS*PIX_W-1:0] oe_round(input logic [TAPS*PIX_W-1:0] v,
                                                     input int first);
    logic [TAPS*PIX_W-1:0] r;
    logic [PIX_W-1:0] a, b;
    r = v;
    for (int p = first; p + 1 < TAPS; p += 2) begin
      a = v[p*PIX_W +: PIX_W];
      b = v[(p+1)*PIX_W +: PIX_W];
      if (a < b) begin
        r[p*PIX_W +: PIX_W]     = a;
        r[(p+1)*PIX_W +: PIX_W] = b;
      end else begin
        r[p*PIX_W +: PIX_W]     = b;
        r[(p+1)*PIX_W +: PIX_W] = a;
      end
    end
    return r;
  endfunction

  logic [TAPS*PIX_W-1:0] win_vec;
  logic [TAPS*PIX_W-1:0] stage [1:ROUNDS];
  logic [ROUNDS-1:0]     vpipe;

  assign win_vec = {h2, h1, h0};

  generate
    for (genvar k = 1; k <= ROUNDS; k++) begin : g_round
      if (k == 1) begin : g_head
        always_ff @(posedge clk) stage[k] <= oe_round(win_vec, 0);
      end else begin : g_body
        always_ff @(posedge clk) stage[k] <= oe_round(stage[k-1], (k - 1) % 2);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[ROUNDS-2:0], win_vld};
  end

  assign out_valid = vpipe[ROUNDS-1];
  assign out_pix   = stage[ROUNDS][MID*PIX_W +: PIX_W];

  // R2
  sorted_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (stage[ROUNDS][(MID-1)*PIX_W +: PIX_W] <= out_pix) &&
                  (out_pix <= stage[ROUNDS][(MID+1)*PIX_W +: PIX_W]));
  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !out_valid);
  // R8
  dim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(dim_q));
  // R7
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && dim_q >= MIN_DIM) |-> (col_idx < dim_q));
  // R7
  win_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> $past(col_idx) >= FIRST_WIN);
endmodule

// File: tb/median3x3_stream_test.sv
module median3x3_stream_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        st0 = 0, v0 = 0, st1 = 0, v1 = 0;
  logic [11:0] d0 = 0, d1 = 0;
  logic [23:0] px0 = 0;
  logic [7:0]  px1 = 0;
  logic        ov0, ov1;
  logic [7:0]  op0, op1;

  median3x3_stream #(.PIX_W(8), .CHANNELS(3), .DIM_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .start(st0), .dim_in(d0), .in_valid(v0),
    .in_pix(px0), .out_valid(ov0), .out_pix(op0));
  median3x3_stream #(.PIX_W(8), .CHANNELS(1), .DIM_W(12)) uut_ser (
    .clk(clk), .rst_n(rst_n), .start(st1), .dim_in(d1), .in_valid(v1),
    .in_pix(px1), .out_valid(ov1), .out_pix(op1));

  int errors = 0, checks = 0, cyc = 0;
  int cnt0 = 0, cnt1 = 0, back2back = 0;
  bit prev1 = 0, done = 0;
  logic [7:0] exp0 [int];
  logic [7:0] exp1 [int];

  int m_dim [2], m_col [2], m_el [2];
  bit m_run [2];
  logic [7:0] m_hist [2][3][3];
  logic [7:0] m_part [2][3];

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic logic [7:0] med_of(int u);
    int q [$];
    for (int c = 0; c < 3; c++)
      for (int r = 0; r < 3; r++) q.push_back(int'(m_hist[u][c][r]));
    q.sort();
    return 8'(q[4]);
  endfunction

  task automatic model_step(int u, bit st, int d, bit v, logic [23:0] px);
    bit fin;
    logic [7:0] col [3];
    fin = 0;
    if (st) begin
      m_dim[u] = d; m_col[u] = 0; m_el[u] = 0; m_run[u] = 1;
      return;
    end
    if (!m_run[u] || !v) return;
    if (u == 0) begin
      col[0] = px[7:0]; col[1] = px[15:8]; col[2] = px[23:16]; fin = 1;
    end else begin
      m_part[u][m_el[u]] = px[7:0];
      if (m_el[u] == 2) begin
        fin = 1; m_el[u] = 0;
        for (int r = 0; r < 3; r++) col[r] = m_part[u][r];
      end else m_el[u]++;
    end
    if (fin) begin
      for (int r = 0; r < 3; r++) begin
        m_hist[u][0][r] = m_hist[u][1][r];
        m_hist[u][1][r] = m_hist[u][2][r];
        m_hist[u][2][r] = col[r];
      end
      if (m_col[u] >= 2 && m_dim[u] >= 3) begin
        if (u == 0) exp0[cyc + LAT] = med_of(u);
        else        exp1[cyc + LAT] = med_of(u);
      end
      m_col[u] = (m_col[u] == m_dim[u] - 1) ? 0 : m_col[u] + 1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      model_step(0, st0, int'(d0), v0, px0);
      model_step(1, st1, int'(d1), v1, {16'h0, px1});
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    bit e;
    e = exp0.exists(cyc) != 0;
    chk(ov0 == e, "R3 valid timing (3-lane)", int'(ov0), int'(e));
    if (e && ov0) chk(op0 == exp0[cyc], "R2 median (3-lane)", op0, exp0[cyc]);
    if (e) exp0.delete(cyc);
    e = exp1.exists(cyc) != 0;
    chk(ov1 == e, "R3 valid timing (1-lane)", int'(ov1), int'(e));
    if (e && ov1) chk(op1 == exp1[cyc], "R2 median (1-lane)", op1, exp1[cyc]);
    if (e) exp1.delete(cyc);
    if (ov0) cnt0++;
    if (ov1) cnt1++;
    if (ov1 && prev1) back2back++;
    prev1 = ov1;
  end

  task automatic beat0(bit st, int d, bit v, logic [23:0] px);
    @(negedge clk); st0 = st; d0 = 12'(d); v0 = v; px0 = px;
  endtask
  task automatic beat1(bit st, int d, bit v, logic [7:0] px);
    @(negedge clk); st1 = st; d1 = 12'(d); v1 = v; px1 = px;
  endtask
  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); st0 = 0; v0 = 0; st1 = 0; v1 = 0;
    end
  endtask

  function automatic logic [23:0] pat(int mode, int k);
    case (mode)
      0: return 24'($urandom);
      1: return 24'h808080;
      2: return {8'(3*k+2), 8'(3*k+1), 8'(3*k)};
      3: return (k % 2) ? 24'hFFFFFF : 24'h00FF00;
      default: return {8'(250-k), 8'(240-k), 8'(230-k)};
    endcase
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=timeout expected=finish");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(ov0 == 0 && ov1 == 0, "R1 reset out_valid", int'(ov0 | ov1), 0);
    rst_n = 1;
    // R1: beats before any start are ignored
    for (int k = 0; k < 6; k++) begin
      beat0(0, 4, 1, pat(0, k));
      beat1(0, 4, 1, 8'(k));
    end
    idle(12);
    chk(cnt0 == 0 && cnt1 == 0, "R1 no output before start", cnt0 + cnt1, 0);

    // R4 R6 R7 R8: full-rate rows of 6; dim_in wiggles after start
    cnt0 = 0;
    beat0(1, 6, 0, 0);
    for (int k = 0; k < 18; k++) beat0(0, (k % 3) + 3, 1, pat(0, k));
    idle(14);
    chk(cnt0 == 12, "R7 three rows of 6 give 12 results", cnt0, 12);

    // R2 R10: patterns with gaps, dim 4
    cnt0 = 0;
    beat0(1, 4, 0, 0);
    for (int m = 1; m <= 4; m++)
      for (int k = 0; k < 8; k++) begin
        beat0(0, 9, 1, pat(m, k));
        if (k % 3 == 1) idle(2);
      end
    idle(14);
    chk(cnt0 == 16, "R10 gapped rows of 4 give 16 results", cnt0, 16);

    // R9: restart with a beat in the start cycle while the pipeline is busy
    cnt0 = 0;
    beat0(1, 5, 0, 0);
    for (int k = 0; k < 5; k++) beat0(0, 5, 1, pat(0, k));
    beat0(1, 3, 1, 24'hFFFFFF);
    for (int k = 0; k < 9; k++) beat0(0, 3, 1, pat(0, k));
    idle(14);
    chk(cnt0 == 6, "R9 restart keeps 3 old and adds 3 new", cnt0, 6);

    // R7: dim below 3 gives nothing
    cnt0 = 0;
    beat0(1, 2, 0, 0);
    for (int k = 0; k < 8; k++) beat0(0, 2, 1, pat(0, k));
    idle(14);
    chk(cnt0 == 0, "R7 dim 2 no results", cnt0, 0);

    // R5: one lane, rows of 5, gaps between lanes
    cnt1 = 0;
    beat1(1, 5, 0, 0);
    for (int k = 0; k < 45; k++) begin
      beat1(0, 7, 1, 8'($urandom));
      if (k % 4 == 2) begin @(negedge clk); v1 = 0; end
    end
    idle(14);
    chk(cnt1 == 9, "R5 one-lane three rows of 5 give 9 results", cnt1, 9);
    chk(back2back == 0, "R5 no consecutive one-lane results", back2back, 0);
    // R3: nothing still pending
    chk(exp0.size() == 0 && exp1.size() == 0, "R3 all results delivered",
        exp0.size() + exp1.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule